// File: doc/BRIEF.md
# Processor Run/Stop Sequencer

This block starts and halts a configurable set of processors in a cluster. Software uses a simple register bus with 64-bit data. A write to the start register brings selected halted processors out of reset. A write to the stop register halts selected running processors. A read of the status register returns a one-bit-per-processor map of the processors that are running.

Each processor has three signals: a one-cycle reset pulse, a one-cycle halt request, and a ready input. The processor raises ready when its start-up has finished. A processor's running bit is set only when its ready is seen, not when the start write happens. The three registers can be reached through two address windows that behave the same. After reset, the block starts the processors named in a build-time mask without any bus access.

The build-time start mask must not name processors that do not exist. Elaboration stops with an error if the mask has a bit set at or above `NUM_VP`.

Top module: `vp_runctl`

## Requirements
- R1: While `rst` is high, `core_rst` and `halt_req` are all zero and the running map is cleared. On the first cycle after the first clock edge with `rst` low, `core_rst` pulses for exactly the processors set in `START_MASK`.
- R2: A start write (window offset 0x28) produces a one-cycle `core_rst` pulse in the cycle after the write edge. The pulse goes only to processors whose data bit is set and that are fully halted (neither running nor starting).
- R3: A running bit becomes set only at a clock edge where that processor is waiting after its reset pulse and its `core_ready` is high. `core_ready` has no effect at any other time, including the pulse cycle itself.
- R4: A stop write (window offset 0x30) clears the running bit of each selected running processor at the write edge. It also gives that processor a one-cycle `halt_req` in the following cycle. Halted or still-starting processors get nothing.
- R5: Start and stop data bits at positions NUM_VP and above are ignored.
- R6: The window at base 0x2000 and the window at base 0x4000 decode the start, stop and status registers identically.
- R7: A read produces `rd_valid` for one cycle after the request edge. A read of the status register (window offset 0x70) returns the running map in bits [NUM_VP-1:0] with zeros above. A read of any other address returns zero, and a write to any other address changes nothing.
- R8: A start write aimed at a processor that is still waiting for its ready gives no second `core_rst` pulse.
- R9: If a processor's ready arrives in the same cycle as a stop write that selects it, the start completes first and the stop then takes effect. The processor ends halted, gets a `halt_req` pulse, and its running bit stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address of the access |
| req_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | 64 | Read data |
| core_ready | input | NUM_VP | Per-processor start-up finished |
| core_rst | output | NUM_VP | Per-processor one-cycle reset pulse |
| halt_req | output | NUM_VP | Per-processor one-cycle halt request |

## Verification
The bench builds the block with NUM_VP = 4 and START_MASK = 0x5, so the automatic start after reset reaches a non-contiguous subset of processors. With four processors, a single write can mix bits of running, starting and halted processors. It can also carry junk above bit 3, which exercises the masking. Each processor can be held in its waiting state while a repeated start, an early stop, or a stop that collides with ready is applied.

// File: rtl/vprc_pkg.sv
package vprc_pkg;

    localparam int unsigned BUS_DW = 64;
    localparam int unsigned BUS_AW = 16;

    // Window bases and register offsets inside each window
    localparam logic [BUS_AW-1:0] WIN_LOCAL = 16'h2000;
    localparam logic [BUS_AW-1:0] WIN_OTHER = 16'h4000;
    localparam logic [BUS_AW-1:0] OFS_START = 16'h0028;
    localparam logic [BUS_AW-1:0] OFS_STOP  = 16'h0030;
    localparam logic [BUS_AW-1:0] OFS_MAP   = 16'h0070;

    typedef enum logic [1:0] {
        VP_HALTED,
        VP_RSTPULSE,
        VP_WAITRDY,
        VP_RUNNING
    } vp_state_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_START,
        SEL_STOP,
        SEL_MAP
    } reg_sel_e;

    function automatic logic [BUS_DW-1:0] vp_valid_mask(input int unsigned n);
        if (n >= BUS_DW) return '1;
        return (BUS_DW'(1) << n) - BUS_DW'(1);
    endfunction

    function automatic reg_sel_e decode_ofs(input logic [BUS_AW-1:0] a);
        if (a == WIN_LOCAL + OFS_START || a == WIN_OTHER + OFS_START) return SEL_START;
        if (a == WIN_LOCAL + OFS_STOP  || a == WIN_OTHER + OFS_STOP)  return SEL_STOP;
        if (a == WIN_LOCAL + OFS_MAP   || a == WIN_OTHER + OFS_MAP)   return SEL_MAP;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/vprc_decode.sv
module vprc_decode import vprc_pkg::*; #(
    parameter int unsigned NUM_VP = 1
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BUS_AW-1:0] req_addr,
    input  logic [BUS_DW-1:0] req_wdata,
    output logic [NUM_VP-1:0] start_bits,
    output logic [NUM_VP-1:0] stop_bits,
    output logic              rd_strobe,
    output logic              rd_map
);
    localparam logic [BUS_DW-1:0] VALID = vp_valid_mask(NUM_VP);

    reg_sel_e          sel;
    logic [BUS_DW-1:0] masked;
    logic              wr_go;
    logic              unused_ok;

    assign sel       = decode_ofs(req_addr);
    assign masked    = req_wdata & VALID;
    assign wr_go     = req_valid && req_write;
    assign unused_ok = ^masked;

    assign start_bits = (wr_go && sel == SEL_START) ? masked[NUM_VP-1:0] : '0;
    assign stop_bits  = (wr_go && sel == SEL_STOP)  ? masked[NUM_VP-1:0] : '0;
    assign rd_strobe  = req_valid && !req_write;
    assign rd_map     = rd_strobe && sel == SEL_MAP;

endmodule

// File: rtl/vprc_slot.sv
module vprc_slot import vprc_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic start_cmd,
    input  logic stop_cmd,
    input  logic core_ready,
    output logic core_rst,
    output logic halt_req,
    output logic running
);
    vp_state_e st, st_nx;
    logic      halt_q;
    logic      stop_fire;

    always_comb begin
        st_nx = st;
        unique case (st)
            VP_HALTED:   if (start_cmd) st_nx = VP_RSTPULSE;
            VP_RSTPULSE: st_nx = VP_WAITRDY;
            // start completion is applied before a same-cycle stop
            VP_WAITRDY:  if (core_ready) st_nx = stop_cmd ? VP_HALTED : VP_RUNNING;
            VP_RUNNING:  if (stop_cmd) st_nx = VP_HALTED;
            default:     st_nx = VP_HALTED;
        endcase
    end

    assign stop_fire = stop_cmd &&
                       (st == VP_RUNNING || (st == VP_WAITRDY && core_ready));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= VP_HALTED;
            halt_q <= 1'b0;
        end else begin
            st     <= st_nx;
            halt_q <= stop_fire;
        end
    end

    assign core_rst = (st == VP_RSTPULSE);
    assign halt_req = halt_q;
    assign running  = (st == VP_RUNNING);

endmodule

// File: rtl/vprc_rdback.sv
module vprc_rdback import vprc_pkg::*; #(
    parameter int unsigned NUM_VP = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_strobe,
    input  logic              rd_map,
    input  logic [NUM_VP-1:0] run_map,
    output logic              rd_valid,
    output logic [BUS_DW-1:0] rd_data
);
    logic [BUS_DW-1:0] map_ext;

    always_comb begin
        map_ext              = '0;
        map_ext[NUM_VP-1:0]  = run_map;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_strobe;
            rd_data  <= rd_map ? map_ext : '0;
        end
    end

endmodule

// File: rtl/vp_runctl.sv
module vp_runctl import vprc_pkg::*; #(
    parameter int unsigned       NUM_VP     = 1,
    parameter logic [BUS_DW-1:0] START_MASK = 64'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BUS_AW-1:0] req_addr,
    input  logic [BUS_DW-1:0] req_wdata,
    output logic              rd_valid,
    output logic [BUS_DW-1:0] rd_data,
    input  logic [NUM_VP-1:0] core_ready,
    output logic [NUM_VP-1:0] core_rst,
    output logic [NUM_VP-1:0] halt_req
);
    localparam logic [BUS_DW-1:0] VALID = vp_valid_mask(NUM_VP);

    // Configuration guards: processor count and boot mask must fit
    if (NUM_VP < 1 || NUM_VP > BUS_DW) begin : g_bad_count
        $error("vp_runctl: NUM_VP out of range");
    end
    if ((START_MASK & ~VALID) != '0) begin : g_bad_boot
        $error("vp_runctl: START_MASK names processors beyond NUM_VP");
    end

    logic [NUM_VP-1:0] dec_start, dec_stop, start_vec, run_map;
    logic              rd_strobe, rd_map;
    logic              boot_q;

    vprc_decode #(.NUM_VP(NUM_VP)) u_decode (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .start_bits (dec_start),
        .stop_bits  (dec_stop),
        .rd_strobe  (rd_strobe),
        .rd_map     (rd_map)
    );

    // Boot start is issued as an ordinary start command (R1)
    always_ff @(posedge clk) begin
        if (rst) boot_q <= 1'b1;
        else     boot_q <= 1'b0;
    end

    assign start_vec = dec_start | (boot_q ? START_MASK[NUM_VP-1:0] : '0);

    for (genvar g = 0; g < NUM_VP; g++) begin : g_slot
        vprc_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .start_cmd  (start_vec[g]),
            .stop_cmd   (dec_stop[g]),
            .core_ready (core_ready[g]),
            .core_rst   (core_rst[g]),
            .halt_req   (halt_req[g]),
            .running    (run_map[g])
        );
    end

    vprc_rdback #(.NUM_VP(NUM_VP)) u_rdback (
        .clk       (clk),
        .rst       (rst),
        .rd_strobe (rd_strobe),
        .rd_map    (rd_map),
        .run_map   (run_map),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/vp_runctl_chk.sv
module vp_runctl_chk import vprc_pkg::*; #(
    parameter int unsigned NUM_VP = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [BUS_AW-1:0] req_addr,
    input logic              rd_valid,
    input logic [BUS_DW-1:0] rd_data,
    input logic [NUM_VP-1:0] core_ready,
    input logic [NUM_VP-1:0] core_rst,
    input logic [NUM_VP-1:0] halt_req,
    input logic [NUM_VP-1:0] run_map
);
    localparam logic [BUS_AW-1:0] MAP_A = WIN_LOCAL + OFS_MAP;
    localparam logic [BUS_AW-1:0] MAP_B = WIN_OTHER + OFS_MAP;

    logic [BUS_DW-1:0] map_ext;
    always_comb begin
        map_ext             = '0;
        map_ext[NUM_VP-1:0] = run_map;
    end

    p_rst_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (core_rst & $past(core_rst)) == '0);

    p_rst_from_halted_r2: assert property (@(posedge clk) disable iff (rst)
        (core_rst & $past(run_map)) == '0);

    p_set_needs_ready_r3: assert property (@(posedge clk) disable iff (rst)
        ((run_map & ~$past(run_map)) & ~$past(core_ready)) == '0);

    p_halt_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        (halt_req & $past(halt_req)) == '0);

    // R4 / R9: a halt request follows a running or just-completing processor
    p_halt_needs_run_r4: assert property (@(posedge clk) disable iff (rst)
        (halt_req & ~($past(run_map) | $past(core_ready))) == '0);

    p_halt_clears_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (halt_req & run_map) == '0);

    p_rd_map_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid && ($past(req_addr) == MAP_A || $past(req_addr) == MAP_B)
        |-> rd_data == $past(map_ext));

    p_rd_other_zero_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid && $past(req_addr) != MAP_A && $past(req_addr) != MAP_B
        |-> rd_data == '0);

endmodule

bind vp_runctl vp_runctl_chk #(.NUM_VP(NUM_VP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_addr   (req_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .core_ready (core_ready),
    .core_rst   (core_rst),
    .halt_req   (halt_req),
    .run_map    (run_map)
);

// File: tb/vp_runctl_tb_top.sv
module vp_runctl_tb_top;
    import vprc_pkg::*;

    localparam int unsigned NVP  = 4;
    localparam logic [63:0] BOOT = 64'h5;

    localparam logic [15:0] L_START = 16'h2028, L_STOP = 16'h2030, L_MAP = 16'h2070;
    localparam logic [15:0] O_START = 16'h4028, O_STOP = 16'h4030, O_MAP = 16'h4070;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0, req_write = 1'b0;
    logic [15:0]     req_addr = '0;
    logic [63:0]     req_wdata = '0;
    logic            rd_valid;
    logic [63:0]     rd_data;
    logic [NVP-1:0]  core_ready = '0;
    logic [NVP-1:0]  core_rst, halt_req;

    int    n_chk = 0, n_fail = 0;
    bit    finished = 1'b0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    vp_runctl #(.NUM_VP(NVP), .START_MASK(BOOT)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .core_ready(core_ready), .core_rst(core_rst),
        .halt_req(halt_req)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver side
    task automatic bus_wr(logic [15:0] a, logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    endtask

    task automatic bus_rd(logic [15:0] a, logic [63:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_addr = '0;
    endtask

    task automatic ready_pulse(logic [NVP-1:0] m);
        @(negedge clk);
        core_ready = m;
        @(negedge clk);
        core_ready = '0;
    endtask

    // Monitor side: compare each read return against the queued expectation
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R7 unexpected rd_valid: actual %h expected none", rd_data);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rd_data, e);
            end
        end
    end

    initial begin
        // R1: quiet during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 core_rst in reset", 64'(core_rst), 64'h0);
            check("R1 halt_req in reset", 64'(halt_req), 64'h0);
        end
        rst = 1'b0;
        @(negedge clk);
        check("R1 boot pulse", 64'(core_rst), 64'h5);
        @(negedge clk);
        check("R1 boot pulse one cycle", 64'(core_rst), 64'h0);
        bus_rd(L_MAP, 64'h0, "R3 map before ready");

        // R3: ready completes start; R6 alias read
        ready_pulse(4'b0101);
        bus_rd(L_MAP, 64'h5, "R3 map after ready");
        bus_rd(O_MAP, 64'h5, "R6 map via other window");

        // R2/R5: start with junk above NUM_VP; VP0 already running
        bus_wr(L_START, 64'hFFFF_FFFF_FFFF_FFF3);
        check("R2 R5 start pulse only VP1", 64'(core_rst), 64'h2);
        @(negedge clk);
        check("R2 pulse one cycle", 64'(core_rst), 64'h0);

        // R8: repeat start while VP1 waits, through other window (R6)
        bus_wr(O_START, 64'h2);
        check("R8 no second pulse", 64'(core_rst), 64'h0);
        ready_pulse(4'b0010);
        bus_rd(L_MAP, 64'h7, "R3 VP1 running");

        // R4/R6: stop VP1 (running) and VP3 (halted) via other window
        bus_wr(O_STOP, 64'hA);
        check("R4 halt only running VP1", 64'(halt_req), 64'h2);
        @(negedge clk);
        check("R4 halt one cycle", 64'(halt_req), 64'h0);
        bus_rd(L_MAP, 64'h5, "R4 map after stop");

        // R5: stop data above NUM_VP only
        bus_wr(L_STOP, 64'hFFFF_FFFF_FFFF_FFF0);
        check("R5 stop high bits ignored", 64'(halt_req), 64'h0);

        // R7: unmapped writes and reads
        bus_wr(16'h2038, 64'hF);
        check("R7 bad write no start", 64'(core_rst), 64'h0);
        check("R7 bad write no halt", 64'(halt_req), 64'h0);
        bus_wr(16'h6028, 64'hF);
        check("R7 outside windows no start", 64'(core_rst), 64'h0);
        bus_rd(L_MAP, 64'h5, "R7 map unchanged by bad writes");
        bus_rd(16'h2000, 64'h0, "R7 other offset reads zero");
        bus_rd(O_START, 64'h0, "R7 start offset reads zero");

        // R4: stop of a still-starting processor is ignored; R3 ready in pulse cycle ignored
        bus_wr(L_START, 64'h8);
        check("R2 start VP3", 64'(core_rst), 64'h8);
        core_ready = 4'b1000;
        @(negedge clk);
        core_ready = '0;
        bus_rd(L_MAP, 64'h5, "R3 ready during pulse ignored");
        bus_wr(L_STOP, 64'h8);
        check("R4 no halt for starting VP3", 64'(halt_req), 64'h0);
        ready_pulse(4'b1000);
        bus_rd(L_MAP, 64'hD, "R4 VP3 started despite early stop");

        // R9: ready and stop in the same cycle
        bus_wr(L_START, 64'h2);
        check("R2 start VP1 again", 64'(core_rst), 64'h2);
        @(negedge clk);
        core_ready = 4'b0010;
        req_valid = 1'b1; req_write = 1'b1; req_addr = L_STOP; req_wdata = 64'h2;
        @(negedge clk);
        core_ready = '0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        check("R9 collision halt pulse", 64'(halt_req), 64'h2);
        bus_rd(L_MAP, 64'hD, "R9 VP1 ends halted");

        // R4: stop all, then restart all (R2)
        bus_wr(L_STOP, 64'hF);
        check("R4 halt all running", 64'(halt_req), 64'hD);
        bus_rd(O_MAP, 64'h0, "R4 map empty");
        bus_wr(O_START, 64'hF);
        check("R2 restart all", 64'(core_rst), 64'hF);

        repeat (4) @(negedge clk);
        check("R7 all reads returned", 64'(exp_q.size()), 64'h0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R7 watchdog expired: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule